// File: doc/BRIEF.md
# Watchdog Configuration Crossing Unit

This block is the configuration front end of a watchdog whose counting logic runs on its own slow clock, unrelated to the bus clock. Software writes three settings from the bus side: the reload value, the prescaler divide value and the window value. Each setting has its own busy flag. The flag goes high when a write is accepted. While it is high, further writes to that setting are refused. It drops by itself once the value has reached the watchdog clock domain and an acknowledge has come back.

The crossing uses a toggle request and a toggle acknowledge per setting. Each is carried by a two-flop synchronizer. The value sits in a bus-side holding register that cannot change while the flag is high. The scheme therefore works at any ratio between the two clocks. It also survives the bus clock being stopped in the middle of a transfer, because the acknowledge toggle waits in its synchronizer until the bus clock runs again.

A key register guards all three settings. Writes are accepted only after the unlock value has been written to it, and any other key value locks them again. A small countdown stub in the watchdog domain consumes the delivered reload and prescaler values.

Top module: `wdg_reg_sync`

## Requirements
- R1: After both resets, all busy flags are 0, writes are locked, and the watchdog-side values are reload 0xFFF, prescaler 0x000 and window 0xFFF.
- R2: The write address picks the target: 0 is the key, 1 the reload, 2 the prescaler and 3 the window. Writing the key value 0x5C3 to address 0 unlocks the settings, and writing any other value to address 0 locks them. A write to address 1, 2 or 3 while locked sets no busy flag and leaves the watchdog-side value unchanged.
- R3: An accepted write to a setting raises its busy flag (bit 0 reload, bit 1 prescaler, bit 2 window) after the next bus clock edge. The other flags are not touched, and no flag rises without an accepted write.
- R4: A write to a setting whose busy flag is high is ignored, and the earlier value is the one delivered.
- R5: A busy flag clears without any software action. When it reads 0, the watchdog-side value already equals the accepted write.
- R6: R5 holds when the bus clock runs slower than twice the watchdog clock frequency.
- R7: If the bus clock stops while a busy flag is high, the transfer completes once the clock returns, and the flag clears with the correct value delivered.
- R8: The stub counter loads a newly delivered reload value. It decrements once every prescaler+1 watchdog clocks, and after reaching 0 it reloads from the reload value.
- R9: The three settings can be in flight at the same time, and each one completes independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock |
| brst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write target: 0 key, 1 reload, 2 prescaler, 3 window |
| wr_data | input | DW | Write data |
| busy | output | 3 | Per-setting update-in-progress flags |
| wclk | input | 1 | Watchdog clock |
| wrst | input | 1 | Synchronous active-high reset, watchdog domain |
| reload_w | output | DW | Reload value in the watchdog domain |
| presc_w | output | DW | Prescaler value in the watchdog domain |
| window_w | output | DW | Window value in the watchdog domain |
| count_w | output | DW | Stub countdown value |

## Verification
A busy flag is due exactly one bus edge after an accepted write, so the bench checks it at the next falling bus edge. Flag clearing has no fixed latency: it takes two to three watchdog clocks for the request and two to three bus clocks for the acknowledge. The reference model therefore leaves the flag pending, checks the delivered value in the first cycle the flag reads 0, and fails any flag that stays high past a bound counted in running bus cycles. The counter stub is checked on falling watchdog edges, one step per tick.

// File: rtl/wdg_sync_pkg.sv
package wdg_sync_pkg;
  localparam int NREG = 3;

  typedef enum logic [1:0] {
    ADDR_KEY    = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_PRESC  = 2'd2,
    ADDR_WINDOW = 2'd3
  } wdg_addr_e;

  localparam int IDX_RELOAD = 0;
  localparam int IDX_PRESC  = 1;
  localparam int IDX_WINDOW = 2;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int DW = 12,
  parameter logic [DW-1:0] KEY_UNLOCK = 12'h5C3
) (
  input  logic          bclk,
  input  logic          brst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          unlocked
);
  import wdg_sync_pkg::*;

  logic key_wr;
  assign key_wr = wr_en && (wr_addr == ADDR_KEY);

  always_ff @(posedge bclk) begin
    if (brst)        unlocked <= 1'b0;
    else if (key_wr) unlocked <= (wr_data == KEY_UNLOCK);
  end

  // R2: a wrong key always relocks
  a_r2_relock: assert property (@(posedge bclk) disable iff (brst)
    (key_wr && wr_data != KEY_UNLOCK) |=> !unlocked);
endmodule

// File: rtl/wdg_xfer_chan.sv
module wdg_xfer_chan #(
  parameter int DW = 12,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          bclk,
  input  logic          brst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  input  logic          wclk,
  input  logic          wrst,
  output logic [DW-1:0] val_w,
  output logic          load_w
);
  // bus domain
  logic [DW-1:0] shadow_q;
  logic          req_q;
  logic          ack_s1, ack_s2;
  logic          accept;

  // watchdog domain
  logic req_s1, req_s2, req_s3;
  logic ack_q;
  logic req_edge;

  assign accept = wr_stb && !busy;

  always_ff @(posedge bclk) begin
    if (brst) begin
      shadow_q <= RST_VAL;
      req_q    <= 1'b0;
      ack_s1   <= 1'b0;
      ack_s2   <= 1'b0;
      busy     <= 1'b0;
    end else begin
      ack_s1 <= ack_q;
      ack_s2 <= ack_s1;
      if (accept) begin
        shadow_q <= wr_data;
        req_q    <= ~req_q;
        busy     <= 1'b1;
      end else begin
        busy     <= (req_q != ack_s2);
      end
    end
  end

  assign req_edge = (req_s2 != req_s3);

  always_ff @(posedge wclk) begin
    if (wrst) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
      ack_q  <= 1'b0;
      val_w  <= RST_VAL;
      load_w <= 1'b0;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      load_w <= req_edge;
      if (req_edge) begin
        val_w <= shadow_q;
        ack_q <= ~ack_q;
      end
    end
  end

  // R3: an accepted write shows as busy after the next bus edge
  a_r3_busy_rise: assert property (@(posedge bclk) disable iff (brst)
    (wr_stb && !busy) |=> busy);
  // R4: holding register frozen while a transfer is outstanding
  a_r4_shadow_hold: assert property (@(posedge bclk) disable iff (brst)
    busy |=> $stable(shadow_q));
  // R5: every detected request is answered by an acknowledge toggle
  a_r5_ack_answers: assert property (@(posedge wclk) disable iff (wrst)
    req_edge |=> (ack_q != $past(ack_q)));
endmodule

// File: rtl/wdg_count_stub.sv
module wdg_count_stub #(
  parameter int DW = 12
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic [DW-1:0] reload_val,
  input  logic          reload_load,
  input  logic [DW-1:0] presc_val,
  input  logic          presc_load,
  output logic [DW-1:0] count
);
  logic [DW-1:0] pcnt_q;
  logic          tick;

  assign tick = (pcnt_q == presc_val);

  always_ff @(posedge wclk) begin
    if (wrst) begin
      pcnt_q <= '0;
      count  <= reload_val;
    end else begin
      if (presc_load || tick) pcnt_q <= '0;
      else                    pcnt_q <= pcnt_q + 1'b1;

      if (reload_load)        count <= reload_val;
      else if (tick) begin
        if (count == '0)      count <= reload_val;
        else                  count <= count - 1'b1;
      end
    end
  end

  // R8: one decrement per prescaler tick
  a_r8_decrement: assert property (@(posedge wclk) disable iff (wrst)
    (!reload_load && tick && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/wdg_reg_sync.sv
module wdg_reg_sync #(
  parameter int DW = 12,
  parameter logic [DW-1:0] KEY_UNLOCK = 12'h5C3,
  parameter logic [DW-1:0] RELOAD_RST = 12'hFFF,
  parameter logic [DW-1:0] PRESC_RST  = 12'h000,
  parameter logic [DW-1:0] WIN_RST    = 12'hFFF
) (
  input  logic                              bclk,
  input  logic                              brst,
  input  logic                              wr_en,
  input  logic [1:0]                        wr_addr,
  input  logic [DW-1:0]                     wr_data,
  output logic [wdg_sync_pkg::NREG-1:0]     busy,
  input  logic                              wclk,
  input  logic                              wrst,
  output logic [DW-1:0]                     reload_w,
  output logic [DW-1:0]                     presc_w,
  output logic [DW-1:0]                     window_w,
  output logic [DW-1:0]                     count_w
);
  import wdg_sync_pkg::*;

  localparam logic [NREG-1:0][DW-1:0] RST_VALS = {WIN_RST, PRESC_RST, RELOAD_RST};

  logic                     unlocked;
  logic [NREG-1:0][DW-1:0]  vals;
  logic [NREG-1:0]          loads;

  wdg_key_gate #(.DW(DW), .KEY_UNLOCK(KEY_UNLOCK)) u_key (
    .bclk(bclk), .brst(brst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unlocked(unlocked)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_chan
    logic stb;
    assign stb = wr_en && unlocked && (wr_addr == 2'(g + 1));

    wdg_xfer_chan #(.DW(DW), .RST_VAL(RST_VALS[g])) u_chan (
      .bclk(bclk), .brst(brst), .wr_stb(stb), .wr_data(wr_data),
      .busy(busy[g]), .wclk(wclk), .wrst(wrst),
      .val_w(vals[g]), .load_w(loads[g])
    );
  end

  assign reload_w = vals[IDX_RELOAD];
  assign presc_w  = vals[IDX_PRESC];
  assign window_w = vals[IDX_WINDOW];

  wdg_count_stub #(.DW(DW)) u_cnt (
    .wclk(wclk), .wrst(wrst),
    .reload_val(vals[IDX_RELOAD]), .reload_load(loads[IDX_RELOAD]),
    .presc_val(vals[IDX_PRESC]),   .presc_load(loads[IDX_PRESC]),
    .count(count_w)
  );
endmodule

// File: tb/sim_wdg_reg_sync.sv
module sim_wdg_reg_sync;
  localparam int BCLK_PERIOD = 10;
  localparam int DW    = 12;
  localparam int LIMIT = 60;
  localparam logic [DW-1:0] KEY = 12'h5C3;

  logic bclk = 0, wclk = 0, brst = 1, wrst = 1, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [2:0] busy;
  logic [DW-1:0] reload_w, presc_w, window_w, count_w;

  int bhalf = BCLK_PERIOD / 2;
  int whalf = 23;
  bit brun = 1;
  int checks = 0, errors = 0;

  bit unl = 0;
  bit pend [3];
  bit jset [3];
  int age  [3];
  logic [DW-1:0] expv [3];
  string ctag = "R5";

  wdg_reg_sync u0 (
    .bclk(bclk), .brst(brst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .wclk(wclk), .wrst(wrst), .reload_w(reload_w), .presc_w(presc_w),
    .window_w(window_w), .count_w(count_w)
  );

  always begin #(bhalf); if (brun) bclk = ~bclk; end
  always begin #(whalf); wclk = ~wclk; end

  function automatic logic [DW-1:0] outv(int i);
    case (i)
      0: return reload_w;
      1: return presc_w;
      default: return window_w;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge bclk);
    for (int i = 0; i < 3; i++) begin
      if (jset[i]) begin
        check(busy[i] == 1'b1, "R3", $sformatf("busy[%0d] after write", i), busy[i], 1);
        jset[i] = 0;
      end else if (pend[i]) begin
        if (!busy[i]) begin
          check(outv(i) == expv[i], ctag, $sformatf("value %0d on clear", i), outv(i), expv[i]);
          pend[i] = 0;
        end else begin
          age[i]++;
          if (age[i] > LIMIT) begin
            check(0, ctag, $sformatf("busy[%0d] stuck", i), age[i], LIMIT);
            pend[i] = 0;
          end
        end
      end else begin
        check(busy[i] == 1'b0, "R3", $sformatf("spurious busy[%0d]", i), busy[i], 0);
      end
    end
  endtask

  task automatic write(logic [1:0] a, logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    if (a == 2'd0) unl = (d == KEY);
    else if (unl && !pend[a-1]) begin
      pend[a-1] = 1; jset[a-1] = 1; age[a-1] = 0; expv[a-1] = d;
    end
    step();
    wr_en = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 400 && (pend[0] || pend[1] || pend[2]); n++) step();
    step();
  endtask

  initial begin
    #(BCLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin pend[i] = 0; jset[i] = 0; age[i] = 0; end
    repeat (4) @(negedge wclk);
    wrst = 0;
    repeat (4) @(negedge bclk);
    brst = 0;
    // R1 reset state
    step();
    check(busy == 3'b000, "R1", "busy after reset", busy, 0);
    check(reload_w == 12'hFFF, "R1", "reload reset", reload_w, 12'hFFF);
    check(presc_w == 12'h000, "R1", "presc reset", presc_w, 0);
    check(window_w == 12'hFFF, "R1", "window reset", window_w, 12'hFFF);

    // R2 locked after reset: write ignored
    write(2'd1, 12'h111);
    repeat (40) step();
    check(reload_w == 12'hFFF, "R2", "locked reload write", reload_w, 12'hFFF);

    // R4 second write while busy is dropped
    write(2'd0, KEY);
    write(2'd1, 12'h0AB);
    write(2'd1, 12'h0CD);
    wait_done();
    check(reload_w == 12'h0AB, "R4", "ignored write while busy", reload_w, 12'h0AB);

    // R9 all three in flight
    write(2'd2, 12'h003);
    write(2'd3, 12'h800);
    write(2'd1, 12'h010);
    check(busy == 3'b111, "R9", "all flags high", busy, 3'b111);
    wait_done();
    check(window_w == 12'h800 && presc_w == 12'h003, "R9", "window/presc", window_w, 12'h800);

    // R6 bus slower than twice watchdog clock
    ctag = "R6";
    bhalf = 40; whalf = 7;
    repeat (3) step();
    write(2'd3, 12'h0F0);
    write(2'd2, 12'h001);
    wait_done();
    check(window_w == 12'h0F0, "R6", "slow bus window", window_w, 12'h0F0);

    // R7 bus clock stopped while busy
    ctag = "R7";
    bhalf = BCLK_PERIOD / 2; whalf = 23;
    repeat (3) step();
    write(2'd1, 12'h222);
    brun = 0;
    #(whalf * 2 * 30);
    brun = 1;
    wait_done();
    check(busy == 3'b000, "R7", "flags clear after clock return", busy, 0);
    check(reload_w == 12'h222, "R7", "reload after stop", reload_w, 12'h222);

    // R2 relock with a wrong key
    ctag = "R5";
    write(2'd0, 12'h001);
    write(2'd2, 12'h007);
    repeat (40) step();
    check(presc_w == 12'h001, "R2", "relocked presc write", presc_w, 12'h001);

    // R8 counter stub
    write(2'd0, KEY);
    write(2'd2, 12'h000);
    write(2'd1, 12'h005);
    wait_done();
    begin
      logic [DW-1:0] prev, expc;
      @(negedge wclk); prev = count_w;
      for (int k = 0; k < 20; k++) begin
        @(negedge wclk);
        expc = (prev == 0) ? 12'h005 : prev - 1'b1;
        check(count_w == expc, "R8", "count step presc 0", count_w, expc);
        prev = count_w;
      end
    end
    @(negedge bclk);
    write(2'd2, 12'h002);
    wait_done();
    begin
      logic [DW-1:0] prev, expc;
      int since, nchg;
      since = 0; nchg = 0;
      @(negedge wclk); prev = count_w;
      for (int k = 0; k < 40; k++) begin
        @(negedge wclk);
        since++;
        if (count_w != prev) begin
          expc = (prev == 0) ? 12'h005 : prev - 1'b1;
          check(count_w == expc, "R8", "count value presc 2", count_w, expc);
          if (nchg > 0) check(since == 3, "R8", "tick spacing presc 2", since, 3);
          nchg++;
          since = 0;
          prev = count_w;
        end
      end
      check(nchg >= 12, "R8", "tick count presc 2", nchg, 12);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule